// File: doc/BRIEF.md
# Local interrupt controller timer

This block is the countdown timer of a processor's local interrupt controller. It has no decrementing counter. It records the value of a free-running time base at the moment software loads an initial count. From then on it derives elapsed ticks by subtracting that load time from the present time base and dividing the result by a programmable power of two. The current count and every expiry follow from elapsed ticks and the initial count alone.

A small register port holds three things: the timer's vector-table entry (interrupt vector, mask and mode), the initial count and the divide code. The current count is read back through the same port. In one-shot mode the timer expires once. In periodic mode it expires every initial count plus one ticks. Each expiry that is not masked produces a one-clock interrupt request that carries the programmed vector.

Top module: `lapic_timer`

## Requirements
- R1: The divide register (select 3) uses bits 3, 1 and 0 as a code v = {bit3, bit1, bit0}. The shift is v+1 for v from 0 to 6, giving divide-by-2 up to divide-by-128, and v = 7 gives shift 0 (divide-by-1). Bit 2 is not stored and reads as 0.
- R2: In one-shot mode the current count reads initial count minus elapsed ticks, and reads 0 once elapsed ticks reach or pass the initial count. Elapsed ticks are (time base − load time) >> shift.
- R3: In periodic mode the current count reads initial count − (elapsed ticks mod (initial count + 1)).
- R4: In one-shot mode with a nonzero initial count, exactly one request fires, on the clock after the edge at which elapsed ticks first equal initial count + 1. The request carries the vector from bits 7:0 of the vector-table entry.
- R5: In periodic mode with a nonzero initial count, a request fires each time elapsed ticks reach a new nonzero multiple of initial count + 1.
- R6: In periodic mode an initial count of 0 never raises a request, and the current count reads 0.
- R7: While bit 16 (mask) of the vector-table entry is set, no request is raised. The periodic timeline keeps advancing, so requests resume on later multiples after the mask is cleared.
- R8: Writing the initial count (select 1) captures the present time base as the new load time and restarts the count. Writing 0 in one-shot mode stops the timer, so no further request fires.
- R9: On reset the vector-table entry reads 0x0001_0000 (masked, one-shot, vector 0), and the initial count, divide code and current count read 0. No request is raised.
- R10: Register selects are 0 for the vector-table entry (bits 7:0 vector, bit 16 mask, bit 17 periodic), 1 for the initial count, 2 for the current count and 3 for divide. A write to select 2 is ignored. The mode bit takes effect at the next initial-count write.
- R11: A request lasts exactly one clock. While the time base stalls it does not repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_now_i | input | 48 | Free-running time base; advances by 0 or 1 per clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | One-clock interrupt request on expiry |
| irq_vec_o | output | 8 | Vector carried with the request |

## Verification
The assertions assume that the time base moves forward by at most one step per clock. This keeps the expiry tracker to one period of catch-up per cycle. They also assume that the divide code is changed only while the timer is stopped, since a new divide would rescale ticks that have already elapsed. The stimulus drives the time base from a counter that either increments or stalls. Divide is always written after the timer has been stopped by an initial count of zero and before the next load. The one-shot mask path is exercised only with the mask held for the whole run.

// File: rtl/lapic_tmr_pkg.sv
package lapic_tmr_pkg;

  typedef enum logic [1:0] {
    SEL_LVT  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_DIV  = 2'd3
  } reg_sel_e;

  localparam int VEC_W        = 8;
  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_PER_BIT  = 17;
  localparam int DIV_CODE_W   = 3;
  localparam int SHIFT_W      = 3;

  // code 0..6 -> shift 1..7, code 7 -> shift 0 (wraps)
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_CODE_W-1:0] code);
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/lapic_tmr_regs.sv
module lapic_tmr_regs
  import lapic_tmr_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int REG_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_sel_i,
  input  logic [REG_W-1:0]      wr_data_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  mask_o,
  output logic                  lvt_per_o,
  output logic                  per_act_o,
  output logic [COUNT_W-1:0]    init_o,
  output logic [DIV_CODE_W-1:0] div_code_o,
  output logic                  load_o,
  output logic [COUNT_W-1:0]    load_val_o
);

  reg_sel_e sel;
  logic     lvt_we, div_we;

  logic [VEC_W-1:0]      vec_q, vec_d;
  logic                  mask_q, mask_d;
  logic                  lper_q, lper_d;
  logic                  pact_q, pact_d;
  logic [COUNT_W-1:0]    init_q, init_d;
  logic [DIV_CODE_W-1:0] div_q, div_d;

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[REG_W-1:LVT_PER_BIT+1], wr_data_i[2]};

  assign sel        = reg_sel_e'(wr_sel_i);
  assign lvt_we     = wr_en_i && (sel == SEL_LVT);
  assign div_we     = wr_en_i && (sel == SEL_DIV);
  assign load_o     = wr_en_i && (sel == SEL_INIT);
  assign load_val_o = wr_data_i[COUNT_W-1:0];

  always_comb begin
    vec_d  = vec_q;
    mask_d = mask_q;
    lper_d = lper_q;
    pact_d = pact_q;
    init_d = init_q;
    div_d  = div_q;
    if (lvt_we) begin
      vec_d  = wr_data_i[VEC_W-1:0];
      mask_d = wr_data_i[LVT_MASK_BIT];
      lper_d = wr_data_i[LVT_PER_BIT];
    end
    if (load_o) begin
      init_d = load_val_o;
      pact_d = lper_q;            // mode is taken at load time
    end
    if (div_we) begin
      div_d = {wr_data_i[3], wr_data_i[1], wr_data_i[0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      lper_q <= 1'b0;
      pact_q <= 1'b0;
      init_q <= '0;
      div_q  <= '0;
    end else begin
      vec_q  <= vec_d;
      mask_q <= mask_d;
      lper_q <= lper_d;
      pact_q <= pact_d;
      init_q <= init_d;
      div_q  <= div_d;
    end
  end

  assign vec_o      = vec_q;
  assign mask_o     = mask_q;
  assign lvt_per_o  = lper_q;
  assign per_act_o  = pact_q;
  assign init_o     = init_q;
  assign div_code_o = div_q;

endmodule

// File: rtl/lapic_tmr_elapsed.sv
module lapic_tmr_elapsed
  import lapic_tmr_pkg::*;
#(
  parameter int TIME_W = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [TIME_W-1:0]     time_now_i,
  input  logic [DIV_CODE_W-1:0] div_code_i,
  output logic [TIME_W-1:0]     elapsed_o
);

  logic [TIME_W-1:0]  load_time_q, load_time_d;
  logic [TIME_W-1:0]  raw_diff;
  logic [SHIFT_W-1:0] shift;

  always_comb begin
    load_time_d = load_time_q;
    if (load_i) load_time_d = time_now_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_time_q <= '0;
    else         load_time_q <= load_time_d;
  end

  assign shift     = div_shift(div_code_i);
  assign raw_diff  = time_now_i - load_time_q;
  assign elapsed_o = raw_diff >> shift;

  // input contract: the time base never jumps by more than one step
  AST_TB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_now_i - $past(time_now_i)) <= TIME_W'(1)); // R11

endmodule

// File: rtl/lapic_tmr_expiry.sv
module lapic_tmr_expiry
  import lapic_tmr_pkg::*;
#(
  parameter int TIME_W  = 48,
  parameter int COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [COUNT_W-1:0] load_val_i,
  input  logic               per_i,
  input  logic               mask_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [COUNT_W-1:0] init_i,
  input  logic [TIME_W-1:0]  elapsed_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [COUNT_W-1:0] cur_count_o
);

  localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

  logic [TIME_W-1:0] next_q, next_d;
  logic              armed_q, armed_d;
  logic              irq_q, irq_d;
  logic [VEC_W-1:0]  ivec_q, ivec_d;

  logic [TIME_W-1:0] ic_ext, period, eff_next, per_diff, os_diff;
  logic              hit;

  assign ic_ext = TIME_W'(init_i);
  assign period = ic_ext + ONE;
  assign hit    = armed_q && (elapsed_i >= next_q);

  always_comb begin
    next_d  = next_q;
    armed_d = armed_q;
    irq_d   = 1'b0;
    if (load_i) begin
      next_d  = TIME_W'(load_val_i) + ONE;
      armed_d = (load_val_i != '0);
    end else begin
      if (hit) irq_d = !mask_i;
      if (per_i) begin
        if (hit) next_d = next_q + period;
      end else if (hit || (armed_q && mask_i && (elapsed_i >= ic_ext))) begin
        armed_d = 1'b0;
      end
    end
    ivec_d = ivec_q;
    if (irq_d) ivec_d = vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q  <= ONE;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      ivec_q  <= '0;
    end else begin
      next_q  <= next_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
      ivec_q  <= ivec_d;
    end
  end

  // current count from elapsed ticks and the tracked next expiry
  assign eff_next = (elapsed_i >= next_q) ? next_q + period : next_q;
  assign per_diff = eff_next - ONE - elapsed_i;
  assign os_diff  = ic_ext - elapsed_i;

  logic unused_hi;
  assign unused_hi = ^{per_diff[TIME_W-1:COUNT_W], os_diff[TIME_W-1:COUNT_W]};

  always_comb begin
    if (per_i) begin
      cur_count_o = (init_i == '0) ? '0 : per_diff[COUNT_W-1:0];
    end else begin
      cur_count_o = (elapsed_i >= ic_ext) ? '0 : os_diff[COUNT_W-1:0];
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = ivec_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R11
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !irq_o); // R7
  AST_ZERO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (load_val_i == '0)) |=> ##1 !irq_o); // R8
  AST_PERIOD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i && (init_i == '0)) |=> !irq_o); // R6
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_count_o <= init_i); // R2

endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_tmr_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int TIME_W  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_now_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o
);

  localparam int REG_W = 32;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [VEC_W-1:0]      vec;
  logic                  mask, lvt_per, per_act, load;
  logic [COUNT_W-1:0]    init_cnt, load_val, cur_cnt;
  logic [DIV_CODE_W-1:0] div_code;
  logic [TIME_W-1:0]     elapsed;

  lapic_tmr_regs #(.COUNT_W(COUNT_W), .REG_W(REG_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .vec_o      (vec),
    .mask_o     (mask),
    .lvt_per_o  (lvt_per),
    .per_act_o  (per_act),
    .init_o     (init_cnt),
    .div_code_o (div_code),
    .load_o     (load),
    .load_val_o (load_val)
  );

  lapic_tmr_elapsed #(.TIME_W(TIME_W)) elapsed_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .load_i     (load),
    .time_now_i (time_now_i),
    .div_code_i (div_code),
    .elapsed_o  (elapsed)
  );

  lapic_tmr_expiry #(.TIME_W(TIME_W), .COUNT_W(COUNT_W)) expiry_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .load_i      (load),
    .load_val_i  (load_val),
    .per_i       (per_act),
    .mask_i      (mask),
    .vec_i       (vec),
    .init_i      (init_cnt),
    .elapsed_i   (elapsed),
    .irq_o       (irq_o),
    .irq_vec_o   (irq_vec_o),
    .cur_count_o (cur_cnt)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (reg_sel_e'(rd_sel_i))
      SEL_LVT: begin
        rd_data_o[VEC_W-1:0]    = vec;
        rd_data_o[LVT_MASK_BIT] = mask;
        rd_data_o[LVT_PER_BIT]  = lvt_per;
      end
      SEL_INIT: rd_data_o = REG_W'(init_cnt);
      SEL_CUR:  rd_data_o = REG_W'(cur_cnt);
      SEL_DIV:  rd_data_o[3:0] = {div_code[2], 1'b0, div_code[1], div_code[0]};
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: tb/lapic_timer_tb.sv
module lapic_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] time_now;
  logic        tick_en;
  logic        wr_en;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        irq;
  logic [7:0]  irq_vec;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lapic_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .time_now_i(time_now),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq), .irq_vec_o(irq_vec)
  );

  // time base and the values the design saw at the last two edges
  longint t_seen1, t_seen2;
  always @(posedge clk) begin
    if (tick_en) time_now <= time_now + 48'd1;
    t_seen2 <= t_seen1;
    t_seen1 <= longint'(time_now);
  end

  // reference model state
  longint m_L, m_ic;
  int     m_s;
  bit     m_per, m_lper, m_mask;
  logic [7:0] m_vec;

  // {div code[4], periodic, initial count[16], expected pulses in 40 cycles}
  localparam logic [28:0] TAB [8] = '{
    {4'hB, 1'b0, 16'd5, 8'd1},
    {4'h0, 1'b1, 16'd3, 8'd5},
    {4'h1, 1'b1, 16'd1, 8'd5},
    {4'hB, 1'b1, 16'd0, 8'd0},
    {4'h2, 1'b0, 16'd4, 8'd1},
    {4'h8, 1'b0, 16'd2, 8'd0},
    {4'hB, 1'b1, 16'd9, 8'd4},
    {4'hA, 1'b0, 16'd0, 8'd0}
  };

  function automatic int shift_of(input logic [3:0] c);
    return ({c[3], c[1], c[0]} == 3'd7) ? 0 : int'({c[3], c[1], c[0]}) + 1;
  endfunction

  function automatic longint ticks(input longint t);
    return (t < m_L) ? -1 : ((t - m_L) >>> m_s);
  endfunction

  function automatic longint exp_count(input longint t);
    longint e = ticks(t);
    if (m_per) return (m_ic == 0) ? 0 : m_ic - (e % (m_ic + 1));
    return (e >= m_ic) ? 0 : m_ic - e;
  endfunction

  function automatic bit exp_fire(input longint t, input longint tp);
    longint e  = ticks(t);
    longint ep = ticks(tp);
    if (m_mask || m_ic == 0 || e == ep || e <= 0) return 0;
    if (m_per) return (e % (m_ic + 1)) == 0;
    return e == m_ic + 1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: begin m_vec = d[7:0]; m_mask = d[16]; m_lper = d[17]; end
      2'd1: begin m_ic = longint'(d); m_L = t_seen1; m_per = m_lper; end
      2'd3: m_s = shift_of(d[3:0]);
      default: ;
    endcase
  endtask

  task automatic rdchk(input logic [1:0] sel, input longint exp, input string req);
    rd_sel = sel;
    #1;
    chk(req, longint'(rd_data), exp);
    rd_sel = 2'd2;
  endtask

  task automatic run(input int n, input int exp_pulses, input string req);
    int pulses = 0;
    bit f;
    rd_sel = 2'd2;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      f = exp_fire(t_seen1, t_seen2);
      chk({req, (m_per ? " R5 irq" : " R4 irq")}, longint'(irq), longint'(f));
      if (irq) begin
        pulses++;
        chk("R4 vector", longint'(irq_vec), longint'(m_vec));
      end
      chk(m_per ? "R3 count" : "R2 count", longint'(rd_data), exp_count(longint'(time_now)));
    end
    if (exp_pulses >= 0) chk({req, " pulses"}, pulses, exp_pulses);
  endtask

  task automatic model_reset();
    m_L = 0; m_ic = 0; m_s = 1; m_per = 0; m_lper = 0; m_mask = 1; m_vec = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; time_now = '0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = 2'd2;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    rdchk(2'd0, 64'h1_0000, "R9 lvt");
    rdchk(2'd1, 0, "R9 init");
    rdchk(2'd2, 0, "R9 count");
    rdchk(2'd3, 0, "R9 div");
    chk("R9 irq", longint'(irq), 0);
    run(10, 0, "R9");

    // table walk: divide codes, modes, counts (R1 R2 R3 R4 R5 R6)
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, 32'd0);
      wr(2'd3, {28'd0, TAB[i][28:25]});
      wr(2'd0, {14'd0, TAB[i][24], 1'b0, 8'd0, 8'h20 + 8'(i)});
      wr(2'd1, {16'd0, TAB[i][23:8]});
      rdchk(2'd3, longint'(TAB[i][28:25]), "R1 div readback");
      run(40, int'(TAB[i][7:0]), (TAB[i][23:8] == 0 && TAB[i][24]) ? "R6" : "R1");
    end

    // R1 code 1111: bit 2 dropped, divide by 1
    wr(2'd1, 32'd0);
    wr(2'd3, 32'hF);
    rdchk(2'd3, 64'hB, "R1 div bit2");
    wr(2'd0, 32'h0000_0031);
    wr(2'd1, 32'd3);
    run(10, 1, "R1");

    // R7 mask: periodic masked, then unmasked
    wr(2'd1, 32'd0);
    wr(2'd3, 32'hB);
    wr(2'd0, 32'h0003_0055);
    wr(2'd1, 32'd3);
    run(20, 0, "R7");
    wr(2'd0, 32'h0002_0055);
    run(20, -1, "R7");

    // R8 zero write stops one-shot; reload restarts
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0000_0066);
    wr(2'd1, 32'd10);
    run(4, 0, "R8");
    wr(2'd1, 32'd0);
    run(20, 0, "R8");
    wr(2'd0, 32'h0002_0066);
    wr(2'd1, 32'd4);
    run(7, -1, "R8");
    wr(2'd1, 32'd4);
    run(12, 2, "R8");

    // R11 time base stall at an expiry
    wr(2'd1, 32'd0);
    wr(2'd1, 32'd2);
    run(2, 0, "R11");
    tick_en = 1'b0;
    run(6, 1, "R11");
    tick_en = 1'b1;
    run(10, -1, "R11");

    // R10 write to current count ignored, mode latched at load
    wr(2'd2, 32'h1234);
    rdchk(2'd1, 2, "R10 init");
    run(10, -1, "R10");
    wr(2'd0, 32'h0000_0077);
    run(9, 3, "R10");

    // R9 asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R9 irq in reset", longint'(irq), 0);
    rdchk(2'd0, 64'h1_0000, "R9 lvt in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rdchk(2'd1, 0, "R9 init after reset");
    run(10, 0, "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule